// File: doc/BRIEF.md
# Critical-Word-First Read Cache

This block sits between a 32-bit processor pipeline and a simple request/acknowledge memory bus. The core presents word-aligned byte addresses over a valid/ready request channel. A lookup that hits returns the stored word on the edge after acceptance. A lookup that misses allocates a line and refills it from the bus. The refill starts at the word the core asked for and wraps around the line. The core receives its word on the edge after that first bus beat, while the remaining beats complete in the background.

The geometry is set by parameters: line count (default 256), words per line (default 8), and ways (default 1). Line count and words per line must be powers of two of at least 2. A set with more than one way picks its victim with its own round-robin pointer. Only addresses in the window from `BASE` (inclusive, default 0x00000000) to `LIMIT` (exclusive, default 0x80000000) are cached. Any other address is passed to the bus as a single transfer. Writes are write-through: a write always becomes one bus write, and it also updates the cached word if the line is present. A write that misses allocates nothing.

The request channel applies back-pressure: `req_ready` is high only while no bus activity is in progress, so a request that arrives during a refill waits until the refill ends. The response channel has no back-pressure. `rsp_valid` is a single-cycle pulse, one per accepted request, and the core must take it.

Top module: `cwf_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `rsp_valid` and `bus_req` are low; the first cacheable read of any address misses.
- R2: A cacheable read hit gives `rsp_valid` with the stored word right after the accepting edge, one cycle of latency, and causes no bus transfer.
- R3: A read miss fetches all words of the line, one bus beat each. The first beat is at the missed word's offset (address bits above bit 1, within the line). Later beats step the offset by one, wrapping modulo the line length.
- R4: On a read miss the response follows the first bus beat by one edge. With a zero-wait bus this is two cycles from acceptance, independent of line length, and it comes while the rest of the line is still filling.
- R5: `req_ready` is low whenever `bus_req` is high, so no request is accepted during a refill or a bypass transfer.
- R6: An address below `BASE` or at or above `LIMIT` causes exactly one bus transfer at that exact address, responds one edge after its acknowledge, and is never allocated: repeating it goes to the bus again.
- R7: Every write becomes exactly one bus write with the request's address and data. When the line is present, the cached word is updated, so a later read hits with the new value. A write miss does not allocate, so a later read of that address misses.
- R8: With more than one way, each set's victim is chosen by a round-robin pointer that starts at way 0 and advances on every allocation in that set.
- R9: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 32 | Byte address, word aligned |
| req_we | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Read data (zero for writes) |
| bus_req | output | 1 | Bus transfer requested |
| bus_ack | input | 1 | Transfer completes on this edge when requested |
| bus_addr | output | 32 | Bus byte address |
| bus_we | output | 1 | Bus transfer is a write |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |

## Verification
The assertions assume that `bus_ack` only matters while `bus_req` is high, and that the bus answers every request eventually. They also assume request addresses are word aligned and that the core never stalls a response. The bench keeps within these limits: its bus model raises `bus_ack` only with `bus_req`, after a programmable number of wait cycles. It drives only aligned addresses, and it holds each request until `req_ready` lets it in. The bench also samples `rsp_valid` in every cycle, so no response is dropped.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_BYPASS = 2'd2
  } cwf_state_e;
endpackage

// File: rtl/cwf_tag_store.sv
module cwf_tag_store
  import cwf_pkg::*;
#(
  parameter int unsigned LINES = 256,
  parameter int unsigned WAYS  = 1,
  parameter int unsigned TAG_W = 21,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] victim_way,
  input  logic             alloc_en,
  input  logic             fill_done,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAY_W-1:0] fill_way
);
  logic [WAYS-1:0]  way_hit;
  logic [WAY_W-1:0] rr_q [LINES];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tags_q [LINES];
    logic [LINES-1:0] vld_q;

    assign way_hit[w] = vld_q[lk_idx] && (tags_q[lk_idx] == lk_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else begin
        if (alloc_en && victim_way == WAY_W'(w)) vld_q[lk_idx] <= 1'b0;
        if (fill_done && fill_way == WAY_W'(w))  vld_q[fill_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_en && victim_way == WAY_W'(w)) tags_q[lk_idx] <= lk_tag;
    end
  end

  assign hit        = |way_hit;
  assign victim_way = rr_q[lk_idx];

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) rr_q[i] <= '0;
    end else if (alloc_en) begin
      rr_q[lk_idx] <= (rr_q[lk_idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[lk_idx] + WAY_W'(1);
    end
  end

  if (WAYS > 1) begin : g_rr_chk
    // R8: every allocation moves the set's pointer to another way
    assert_rr_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> rr_q[$past(lk_idx)] != $past(rr_q[lk_idx]))
      else $error("round-robin pointer did not advance");
  end

  // R1/R3: a line being allocated is not visible until its refill completes
  assert_alloc_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> !hit || $past(lk_idx) != lk_idx || $past(lk_tag) != lk_tag)
    else $error("allocated line hit before refill completed");
endmodule

// File: rtl/cwf_data_store.sv
module cwf_data_store
  import cwf_pkg::*;
#(
  parameter int unsigned LINES = 256,
  parameter int unsigned WORDS = 8,
  parameter int unsigned WAYS  = 1,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned OFF_W = $clog2(WORDS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned DEPTH = WAYS * LINES * WORDS,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     rd_a;
  logic [AW-1:0]     wr_a;

  assign rd_a = AW'((int'(rd_way) * LINES + int'(rd_idx)) * WORDS + int'(rd_off));
  assign wr_a = AW'((int'(wr_way) * LINES + int'(wr_idx)) * WORDS + int'(wr_off));

  assign rd_data = mem_q[rd_a];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_a] <= wr_data;
  end
endmodule

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
#(
  parameter int unsigned LINES = 256,
  parameter int unsigned WORDS = 8,
  parameter int unsigned WAYS  = 1,
  parameter logic [31:0] BASE  = 32'h0000_0000,
  parameter logic [31:0] LIMIT = 32'h8000_0000,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned OFF_W = $clog2(WORDS),
  localparam int unsigned LO    = 2 + OFF_W,
  localparam int unsigned TAG_W = ADDR_W - LO - IDX_W,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hit_way,
  input  logic [WAY_W-1:0]  victim_way,
  output logic              alloc_en,
  output logic              fill_done,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [WAY_W-1:0]  fill_way,
  output logic [WAY_W-1:0]  rd_way,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [OFF_W-1:0]  rd_off,
  input  logic [WORD_W-1:0] rd_data,
  output logic              dwr_en,
  output logic [WAY_W-1:0]  dwr_way,
  output logic [IDX_W-1:0]  dwr_idx,
  output logic [OFF_W-1:0]  dwr_off,
  output logic [WORD_W-1:0] dwr_data
);
  cwf_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WAY_W-1:0]  way_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  logic [OFF_W-1:0] req_off, q_off, beat_off;
  logic [IDX_W-1:0] req_idx, q_idx;
  logic [TAG_W-1:0] req_tag, q_tag;
  logic in_window, accept, beat, last_beat, filling, bypassing;

  assign req_off = req_addr[LO-1:2];
  assign req_idx = req_addr[LO+IDX_W-1:LO];
  assign req_tag = req_addr[ADDR_W-1:LO+IDX_W];
  assign q_off   = addr_q[LO-1:2];
  assign q_idx   = addr_q[LO+IDX_W-1:LO];
  assign q_tag   = addr_q[ADDR_W-1:LO+IDX_W];

  assign beat_off  = q_off + cnt_q;
  assign in_window = (req_addr >= BASE) && (req_addr < LIMIT);
  assign filling   = (state_q == ST_FILL);
  assign bypassing = (state_q == ST_BYPASS);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign bus_req   = filling || bypassing;
  assign beat      = bus_req && bus_ack;
  assign last_beat = (cnt_q == OFF_W'(WORDS - 1));

  assign lk_idx = req_idx;
  assign lk_tag = req_tag;
  assign rd_way = hit_way;
  assign rd_idx = req_idx;
  assign rd_off = req_off;

  assign alloc_en  = accept && in_window && !req_we && !hit;
  assign fill_done = filling && beat && last_beat;
  assign fill_idx  = q_idx;
  assign fill_way  = way_q;

  assign dwr_en   = (accept && in_window && req_we && hit) || (filling && beat);
  assign dwr_way  = filling ? way_q     : hit_way;
  assign dwr_idx  = filling ? q_idx     : req_idx;
  assign dwr_off  = filling ? beat_off  : req_off;
  assign dwr_data = filling ? bus_rdata : req_wdata;

  assign bus_addr  = filling   ? {q_tag, q_idx, beat_off, 2'b00} :
                     bypassing ? addr_q : '0;
  assign bus_we    = bypassing && we_q;
  assign bus_wdata = wdata_q;

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      way_q       <= '0;
      cnt_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
            cnt_q   <= '0;
            if (!in_window || req_we) begin
              state_q <= ST_BYPASS;
            end else if (hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= rd_data;
            end else begin
              state_q <= ST_FILL;
              way_q   <= victim_way;
            end
          end
        end
        ST_FILL: begin
          if (beat) begin
            cnt_q <= cnt_q + OFF_W'(1);
            if (cnt_q == '0) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= bus_rdata;
            end
            if (last_beat) state_q <= ST_IDLE;
          end
        end
        ST_BYPASS: begin
          if (beat) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= we_q ? '0 : bus_rdata;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: an unanswered transfer keeps its request, address and data
  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))
    else $error("bus transfer changed before acknowledge");

  // R3: refill beats step through the same line in wrap-around order
  assert_wrap_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    filling && beat && !last_beat |=>
      bus_addr[LO-1:2] == OFF_W'($past(bus_addr[LO-1:2]) + OFF_W'(1)) &&
      bus_addr[ADDR_W-1:LO] == $past(bus_addr[ADDR_W-1:LO]))
    else $error("refill beat out of wrap order");

  // R4: the requester is released on the edge after the first refill beat
  assert_early_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    filling && beat && cnt_q == '0 |=> rsp_valid)
    else $error("no response after critical word");

  // R5: bus activity only ever starts right after an accepted request
  assert_bus_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(accept))
    else $error("bus activity without accepted request");

  // R6: an out-of-window request goes to the bus at its own address
  assert_bypass_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_window |=> bus_req && bus_addr == $past(req_addr))
    else $error("uncached request not forwarded unchanged");

  // R7: every write reaches the bus as a write
  assert_write_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_we |=> bus_req && bus_we && bus_wdata == $past(req_wdata))
    else $error("write not forwarded to bus");
endmodule

// File: rtl/cwf_cache.sv
module cwf_cache
  import cwf_pkg::*;
#(
  parameter int unsigned LINES = 256,
  parameter int unsigned WORDS = 8,
  parameter int unsigned WAYS  = 1,
  parameter logic [31:0] BASE  = 32'h0000_0000,
  parameter logic [31:0] LIMIT = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_we,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        bus_req,
  input  logic        bus_ack,
  output logic [31:0] bus_addr,
  output logic        bus_we,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned OFF_W = $clog2(WORDS);
  localparam int unsigned TAG_W = ADDR_W - 2 - OFF_W - IDX_W;
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [IDX_W-1:0]  lk_idx, fill_idx, rd_idx, dwr_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              hit, alloc_en, fill_done, dwr_en;
  logic [WAY_W-1:0]  hit_way, victim_way, fill_way, rd_way, dwr_way;
  logic [OFF_W-1:0]  rd_off, dwr_off;
  logic [WORD_W-1:0] rd_data, dwr_data;

  cwf_tag_store #(.LINES(LINES), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag),
    .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
    .alloc_en(alloc_en), .fill_done(fill_done),
    .fill_idx(fill_idx), .fill_way(fill_way)
  );

  cwf_data_store #(.LINES(LINES), .WORDS(WORDS), .WAYS(WAYS)) u_data (
    .clk(clk), .rd_way(rd_way), .rd_idx(rd_idx), .rd_off(rd_off), .rd_data(rd_data),
    .wr_en(dwr_en), .wr_way(dwr_way), .wr_idx(dwr_idx), .wr_off(dwr_off),
    .wr_data(dwr_data)
  );

  cwf_ctrl #(.LINES(LINES), .WORDS(WORDS), .WAYS(WAYS), .BASE(BASE), .LIMIT(LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .hit(hit), .hit_way(hit_way),
    .victim_way(victim_way), .alloc_en(alloc_en), .fill_done(fill_done),
    .fill_idx(fill_idx), .fill_way(fill_way),
    .rd_way(rd_way), .rd_idx(rd_idx), .rd_off(rd_off), .rd_data(rd_data),
    .dwr_en(dwr_en), .dwr_way(dwr_way), .dwr_idx(dwr_idx), .dwr_off(dwr_off),
    .dwr_data(dwr_data)
  );

  // R1: nothing is in flight straight after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> req_ready && !bus_req && !rsp_valid)
    else $error("activity right after reset");
endmodule

// File: tb/cwf_cache_bench.sv
module cwf_cache_bench;
  localparam int unsigned LINES = 4;
  localparam int unsigned WORDS = 4;
  localparam int unsigned WAYS  = 2;
  localparam logic [31:0] BASE  = 32'h0000_0100;
  localparam logic [31:0] LIMIT = 32'h0000_0800;
  localparam int unsigned LINE_B = WORDS * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_addr = '0;
  logic req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic bus_req;
  logic bus_ack;
  logic [31:0] bus_addr;
  logic bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int wait_cyc = 0;
  int wcnt = 0;
  int ready_viol = 0;
  int hold_viol = 0;
  bit pend = 1'b0;
  logic [31:0] pend_a = '0;

  logic [31:0] wmem [logic [31:0]];
  logic [31:0] log_a [$];
  logic        log_w [$];
  logic [31:0] log_d [$];

  always #2 clk = ~clk;

  cwf_cache #(.LINES(LINES), .WORDS(WORDS), .WAYS(WAYS), .BASE(BASE), .LIMIT(LIMIT)) u_cwf_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return {a[15:0] ^ 16'h5A3C, a[31:16] + a[15:0]};
  endfunction

  assign bus_ack = bus_req && (wcnt >= wait_cyc);

  always @(posedge clk) begin
    if (!rst_n) wcnt <= 0;
    else if (bus_req && !bus_ack) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && (bus_addr != pend_a || !bus_req)) hold_viol++;
      pend   = bus_req && !bus_ack;
      pend_a = bus_addr;
      if (bus_req && req_ready) ready_viol++;
      if (bus_req && bus_ack) begin
        log_a.push_back(bus_addr);
        log_w.push_back(bus_we);
        log_d.push_back(bus_wdata);
        if (bus_we) wmem[bus_addr] = bus_wdata;
      end
    end
    bus_rdata = mem_rd(bus_addr);
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic we, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat, output bit busy);
    log_a.delete();
    log_w.delete();
    log_d.delete();
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_we    = we;
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    rd   = rsp_data;
    busy = !req_ready;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic rd_miss(input logic [31:0] a, input string lbl);
    logic [31:0] rd;
    int lat;
    bit busy;
    logic [31:0] line;
    logic [31:0] exp_a;
    access(a, 1'b0, '0, rd, lat, busy);
    chk(rd == mem_rd(a), {lbl, " R3 miss data"}, rd, mem_rd(a));
    chk(lat == 2 + wait_cyc, {lbl, " R4 miss latency"}, lat, 2 + wait_cyc);
    chk(busy, {lbl, " R4 released before line complete"}, busy, 1);
    chk(log_a.size() == WORDS, {lbl, " R3 beat count"}, log_a.size(), WORDS);
    line = a & ~(LINE_B - 1);
    for (int k = 0; k < WORDS && k < log_a.size(); k++) begin
      exp_a = line + ((((a % LINE_B) / 4) + k) % WORDS) * 4;
      chk(log_a[k] == exp_a && !log_w[k], {lbl, " R3 wrap order"}, log_a[k], exp_a);
    end
  endtask

  task automatic rd_hit(input logic [31:0] a, input string lbl);
    logic [31:0] rd;
    int lat;
    bit busy;
    access(a, 1'b0, '0, rd, lat, busy);
    chk(rd == mem_rd(a), {lbl, " R2 hit data"}, rd, mem_rd(a));
    chk(lat == 1, {lbl, " R2 hit latency"}, lat, 1);
    chk(log_a.size() == 0, {lbl, " R2 no bus on hit"}, log_a.size(), 0);
  endtask

  task automatic rd_unc(input logic [31:0] a, input string lbl);
    logic [31:0] rd;
    int lat;
    bit busy;
    access(a, 1'b0, '0, rd, lat, busy);
    chk(rd == mem_rd(a), {lbl, " R6 bypass data"}, rd, mem_rd(a));
    chk(lat == 2 + wait_cyc, {lbl, " R6 bypass latency"}, lat, 2 + wait_cyc);
    chk(log_a.size() == 1, {lbl, " R6 single transfer"}, log_a.size(), 1);
    if (log_a.size() == 1) chk(log_a[0] == a, {lbl, " R6 exact address"}, log_a[0], a);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string lbl);
    logic [31:0] rd;
    int lat;
    bit busy;
    access(a, 1'b1, d, rd, lat, busy);
    chk(lat == 2 + wait_cyc, {lbl, " R7 write latency"}, lat, 2 + wait_cyc);
    chk(log_a.size() == 1, {lbl, " R7 one bus write"}, log_a.size(), 1);
    if (log_a.size() == 1) begin
      chk(log_a[0] == a && log_w[0], {lbl, " R7 write address"}, log_a[0], a);
      chk(log_d[0] == d, {lbl, " R7 write data"}, log_d[0], d);
    end
  endtask

  initial begin
    logic [31:0] base_a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    chk(bus_req == 1'b0, "R1 bus idle after reset", bus_req, 0);

    // R1/R3/R4/R2: every line of both ways misses once, each critical offset used
    wait_cyc = 0;
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < LINES; s++) begin
        base_a = BASE + t * (LINES * LINE_B) + s * LINE_B;
        rd_miss(base_a + ((s + t) % WORDS) * 4, "R1 cold");
        for (int w = 0; w < WORDS; w++) rd_hit(base_a + w * 4, "sweep");
      end
    end
    for (int k = 0; k < 2 * LINES * WORDS; k++) rd_hit(BASE + k * 4, "R8 both ways kept");

    // R4 with wait states, R8 round-robin in set 0
    wait_cyc = 3;
    rd_miss(32'h188, "R8 evict way0");
    rd_hit(32'h140, "R8 way1 kept");
    rd_miss(32'h10C, "R8 evict way1");
    wait_cyc = 0;
    rd_hit(32'h180, "R8 way0 kept");
    rd_miss(32'h144, "R8 evict way0 again");
    rd_hit(32'h100, "R8 way1 kept again");

    // R6 window edges
    wait_cyc = 2;
    rd_unc(32'h0000_00FC, "R6 below base");
    rd_unc(32'h0000_00FC, "R6 below base repeat");
    rd_unc(32'h0000_0800, "R6 at limit");
    rd_unc(32'h0000_0800, "R6 at limit repeat");
    rd_unc(32'hFFFF_FFF0, "R6 top");
    wait_cyc = 0;
    rd_miss(32'h0000_07FC, "R6 last cached word");
    rd_hit(32'h0000_07F0, "R6 last line cached");

    // R7 write-through
    rd_miss(32'h200, "R7 fill");
    wr(32'h208, 32'hDEAD_BEEF, "R7 write hit");
    rd_hit(32'h208, "R7 updated word");
    chk(mem_rd(32'h208) == 32'hDEAD_BEEF, "R7 memory updated", mem_rd(32'h208), 32'hDEAD_BEEF);
    wr(32'h2C4, 32'h1234_5678, "R7 write miss");
    rd_miss(32'h2C4, "R7 no allocate on write");
    rd_hit(32'h20C, "R7 written line kept");
    wait_cyc = 1;
    wr(32'h40, 32'hCAFE_0001, "R7 uncached write");
    rd_unc(32'h40, "R7 uncached readback");
    chk(mem_rd(32'h40) == 32'hCAFE_0001, "R7 uncached memory", mem_rd(32'h40), 32'hCAFE_0001);

    chk(ready_viol == 0, "R5 ready low during bus activity", ready_viol, 0);
    chk(hold_viol == 0, "R9 bus held until ack", hold_viol, 0);
    finish_run();
  end
endmodule